// File: doc/BRIEF.md
# Compound Mantissa Adder with Plus-Two Output

This block is the adding stage of a floating-point adder's mantissa path. It takes two aligned N-bit significands and returns three results in the same combinational pass: A+B, A+B+1 and A+B+2, each with its own carry-out. It does not use a second carry chain to get the third result. A row of half adders first recodes the operands into a bitwise sum vector and a carry vector shifted up by one place. The low bit of the sum vector is saved and then forced to one. A split adder then produces the recoded sum and that sum plus one. The split adder is built from fixed-width sections, and a lookahead stage supplies each section's carry. A fix-up of bit 0 then recovers all three results.

The block also produces the directed-rounding result. It uses the result sign, the rounding mode, and the guard, round and sticky bits that the alignment shifter has dropped. From these it picks A+B, A+B+1 or A+B+2. Normalisation and exponent update are done downstream.

The data interface is valid/ready with no storage. `out_valid_o` equals `in_valid_i` and `in_ready_i` equals `out_ready_i` in the same cycle. The outputs belong to the operands presented in that cycle. While `in_valid_i` is high and `out_ready_i` is low, the producer must hold every data input stable. A transfer takes place in any cycle where valid and ready are both high.

Top module: `compound_adder`

## Requirements
- R1: `{sum_co_o, sum_o}` equals A+B as an (N+1)-bit value.
- R2: `{inc1_co_o, inc1_o}` equals A+B+1, taken modulo 2^(N+1).
- R3: `{inc2_co_o, inc2_o}` equals A+B+2, taken modulo 2^(N+1). For two all-ones operands this wraps to zero.
- R4: R1 to R3 hold whether bit 0 of A xor B is 0 or is 1.
- R5: `sum_co_o` is 1 exactly when A+B is 2^N or more. This is the overflow indicator used by rounding.
- R6: Rounding mode 2'b01 (toward +infinity) with sign 0, overflow set, and at least one of {bit 0 of A+B, guard, round, sticky} set, makes `{rnd_co_o, rnd_o}` equal to A+B+2.
- R7: The same rounding condition as in R6 or R8, but with no overflow, makes the rounded output equal to A+B+1.
- R8: Rounding mode 2'b10 (toward -infinity) with sign 1, overflow set, and at least one of the four bits set, makes the rounded output equal to A+B+2.
- R9: In every other case the rounded output equals A+B. This covers mode 2'b00, the reserved mode 2'b11, a sign that does not match the direction, and all four bits clear.
- R10: `out_valid_o` follows `in_valid_i` and `in_ready_i` follows `out_ready_i` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid_i | input | 1 | Operands and rounding inputs are valid |
| in_ready_i | output | 1 | Block can accept the operands (mirrors downstream ready) |
| a_i | input | DATA_W | Operand A |
| b_i | input | DATA_W | Operand B |
| guard_i | input | 1 | First bit dropped by the alignment shift |
| round_i | input | 1 | Second bit dropped by the alignment shift |
| sticky_i | input | 1 | OR of all other dropped bits |
| sign_i | input | 1 | Sign of the result, 1 = negative |
| mode_i | input | 2 | 00 truncate, 01 toward +inf, 10 toward -inf, 11 reserved (truncate) |
| out_valid_o | output | 1 | Results are valid |
| out_ready_i | input | 1 | Downstream accepts the results |
| sum_o | output | DATA_W | Low bits of A+B |
| sum_co_o | output | 1 | Carry-out of A+B |
| inc1_o | output | DATA_W | Low bits of A+B+1 |
| inc1_co_o | output | 1 | Carry-out of A+B+1 |
| inc2_o | output | DATA_W | Low bits of A+B+2 |
| inc2_co_o | output | 1 | Carry-out of A+B+2 |
| rnd_o | output | DATA_W | Low bits of the rounded mantissa |
| rnd_co_o | output | 1 | Carry-out of the rounded mantissa |

## Verification
The bench drives operand pairs in which bit 0 of A xor B takes both values. A wrong fix-up of bit 0 would make A+B or A+B+2 come out one too high or one too low for only one of those two parities. All-ones operands check that the carry dropped off the top of the shifted carry vector is restored. They also check that A+B+2 wraps to zero; a design that ORed the two carries would report a carry-out of 1 there. Sums of exactly 2^N check overflow detection. The rounding vectors change one condition at a time: mode, sign, overflow, and each of bit 0, guard, round and sticky. A wrong selection would return the neighbouring result.

// File: rtl/cadd_pkg.sv
package cadd_pkg;
  typedef enum logic [1:0] {
    RND_TRUNC = 2'b00,
    RND_POS   = 2'b01,
    RND_NEG   = 2'b10,
    RND_RSVD  = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/cadd_recode.sv
// Half-adder row: bitwise sum and shifted carry vectors.
// Bit 0 of the sum vector is saved, then forced high.
module cadd_recode #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] xs_o,
  output logic [W-1:0] cv_o,
  output logic         lsb_par_o,
  output logic         top_carry_o
);
  logic [W-1:0] bit_sum;
  logic [W-1:0] bit_carry;

  assign bit_sum     = a_i ^ b_i;
  assign bit_carry   = a_i & b_i;
  assign xs_o        = {bit_sum[W-1:1], 1'b1};
  assign cv_o        = {bit_carry[W-2:0], 1'b0};
  assign lsb_par_o   = bit_sum[0];
  assign top_carry_o = bit_carry[W-1];
endmodule

// File: rtl/cadd_section.sv
// One adder section: sum with carry-in 0 and with carry-in 1,
// plus group generate and propagate for the lookahead stage.
module cadd_section #(
  parameter int SW = 16
) (
  input  logic [SW-1:0] x_i,
  input  logic [SW-1:0] y_i,
  output logic [SW-1:0] s0_o,
  output logic [SW-1:0] s1_o,
  output logic          grp_g_o,
  output logic          grp_p_o
);
  logic [SW-1:0] gen;
  logic [SW-1:0] prop;
  logic [SW:0]   gcum;
  logic [SW:0]   pcum;

  assign gen  = x_i & y_i;
  assign prop = x_i ^ y_i;

  always_comb begin
    gcum[0] = 1'b0;
    pcum[0] = 1'b1;
    for (int k = 0; k < SW; k++) begin
      gcum[k+1] = gen[k] | (prop[k] & gcum[k]);
      pcum[k+1] = prop[k] & pcum[k];
    end
    for (int k = 0; k < SW; k++) begin
      s0_o[k] = prop[k] ^ gcum[k];
      s1_o[k] = prop[k] ^ (gcum[k] | pcum[k]);
    end
  end

  assign grp_g_o = gcum[SW];
  assign grp_p_o = pcum[SW];
endmodule

// File: rtl/cadd_lookahead.sv
// Flat lookahead across sections. For every section it gives the
// carry-in for an overall carry-in of 0 and for one of 1.
module cadd_lookahead #(
  parameter int NS = 4
) (
  input  logic [NS-1:0] grp_g_i,
  input  logic [NS-1:0] grp_p_i,
  output logic [NS:0]   cin0_o,
  output logic [NS:0]   cin1_o
);
  always_comb begin
    for (int i = 0; i <= NS; i++) begin
      logic gsum;
      logic pall;
      gsum = 1'b0;
      pall = 1'b1;
      for (int j = i - 1; j >= 0; j--) begin
        gsum = gsum | (grp_g_i[j] & pall);
        pall = pall & grp_p_i[j];
      end
      cin0_o[i] = gsum;
      cin1_o[i] = gsum | pall;
    end
  end
endmodule

// File: rtl/cadd_round_sel.sv
// Directed-rounding choice among the three compound results.
module cadd_round_sel
  import cadd_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W:0] sum_i,
  input  logic [W:0] inc1_i,
  input  logic [W:0] inc2_i,
  input  logic       guard_i,
  input  logic       round_i,
  input  logic       sticky_i,
  input  logic       sign_i,
  input  logic [1:0] mode_i,
  output logic [W:0] rnd_o
);
  rnd_mode_e mode;
  logic      toward_sign;
  logic      inexact_or_odd;
  logic      ovf;

  assign mode           = rnd_mode_e'(mode_i);
  assign toward_sign    = ((mode == RND_POS) && !sign_i) ||
                          ((mode == RND_NEG) &&  sign_i);
  assign inexact_or_odd = sum_i[0] | guard_i | round_i | sticky_i;
  assign ovf            = sum_i[W];

  always_comb begin
    if (toward_sign && inexact_or_odd) begin
      rnd_o = ovf ? inc2_i : inc1_i;
    end else begin
      rnd_o = sum_i;
    end
  end
endmodule

// File: rtl/compound_adder.sv
module compound_adder #(
  parameter int DATA_W = 64,
  parameter int SECT_W = 16
) (
  input  logic              in_valid_i,
  output logic              in_ready_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              guard_i,
  input  logic              round_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              sum_co_o,
  output logic [DATA_W-1:0] inc1_o,
  output logic              inc1_co_o,
  output logic [DATA_W-1:0] inc2_o,
  output logic              inc2_co_o,
  output logic [DATA_W-1:0] rnd_o,
  output logic              rnd_co_o
);
  localparam int NSECT = DATA_W / SECT_W;

  logic [DATA_W-1:0] xs;
  logic [DATA_W-1:0] cv;
  logic              lsb_par;
  logic              top_carry;
  logic [NSECT-1:0]  grp_g;
  logic [NSECT-1:0]  grp_p;
  logic [NSECT:0]    cin0;
  logic [NSECT:0]    cin1;
  logic [DATA_W-1:0] core0;
  logic [DATA_W-1:0] core1;
  logic              co0;
  logic              co1;
  logic [DATA_W:0]   res_sum;
  logic [DATA_W:0]   res_inc1;
  logic [DATA_W:0]   res_inc2;
  logic [DATA_W:0]   res_rnd;

  // stream pass-through: no storage, same-cycle handshake
  assign out_valid_o = in_valid_i;
  assign in_ready_i  = out_ready_i;

  cadd_recode #(.W(DATA_W)) u_recode (
    .a_i         (a_i),
    .b_i         (b_i),
    .xs_o        (xs),
    .cv_o        (cv),
    .lsb_par_o   (lsb_par),
    .top_carry_o (top_carry)
  );

  for (genvar gi = 0; gi < NSECT; gi++) begin : g_sect
    logic [SECT_W-1:0] s0;
    logic [SECT_W-1:0] s1;

    cadd_section #(.SW(SECT_W)) u_sect (
      .x_i     (xs[gi*SECT_W +: SECT_W]),
      .y_i     (cv[gi*SECT_W +: SECT_W]),
      .s0_o    (s0),
      .s1_o    (s1),
      .grp_g_o (grp_g[gi]),
      .grp_p_o (grp_p[gi])
    );

    assign core0[gi*SECT_W +: SECT_W] = cin0[gi] ? s1 : s0;
    assign core1[gi*SECT_W +: SECT_W] = cin1[gi] ? s1 : s0;
  end

  cadd_lookahead #(.NS(NSECT)) u_cla (
    .grp_g_i (grp_g),
    .grp_p_i (grp_p),
    .cin0_o  (cin0),
    .cin1_o  (cin1)
  );

  // The carry shifted out of the carry vector adds back at weight 2^N.
  // XOR keeps the results modulo 2^(N+1), so all-ones + all-ones + 2 wraps.
  assign co0 = top_carry ^ cin0[NSECT];
  assign co1 = top_carry ^ cin1[NSECT];

  // bit 0 fix-up
  always_comb begin
    if (lsb_par) begin
      // core outputs are A+B and A+B+1
      res_sum  = {co0, core0};
      res_inc1 = {co1, core1};
      res_inc2 = {co1, core1[DATA_W-1:1], 1'b1};
    end else begin
      // core outputs are A+B+1 and A+B+2
      res_sum  = {co0, core0[DATA_W-1:1], 1'b0};
      res_inc1 = {co0, core0};
      res_inc2 = {co1, core1};
    end
  end

  cadd_round_sel #(.W(DATA_W)) u_rsel (
    .sum_i    (res_sum),
    .inc1_i   (res_inc1),
    .inc2_i   (res_inc2),
    .guard_i  (guard_i),
    .round_i  (round_i),
    .sticky_i (sticky_i),
    .sign_i   (sign_i),
    .mode_i   (mode_i),
    .rnd_o    (res_rnd)
  );

  assign {sum_co_o,  sum_o}  = res_sum;
  assign {inc1_co_o, inc1_o} = res_inc1;
  assign {inc2_co_o, inc2_o} = res_inc2;
  assign {rnd_co_o,  rnd_o}  = res_rnd;
endmodule

// File: rtl/compound_adder_chk.sv
module compound_adder_chk #(
  parameter int DATA_W = 64
) (
  input logic              in_valid_i,
  input logic              in_ready_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              guard_i,
  input logic              round_i,
  input logic              sticky_i,
  input logic              sign_i,
  input logic [1:0]        mode_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              sum_co_o,
  input logic [DATA_W-1:0] inc1_o,
  input logic              inc1_co_o,
  input logic [DATA_W-1:0] inc2_o,
  input logic              inc2_co_o,
  input logic [DATA_W-1:0] rnd_o,
  input logic              rnd_co_o
);
  logic [DATA_W:0] ref_ab;
  logic [DATA_W:0] got_s;
  logic [DATA_W:0] got_1;
  logic [DATA_W:0] got_2;
  logic [DATA_W:0] got_r;
  logic            up_pos;
  logic            up_neg;
  logic            any_bit;

  assign ref_ab  = {1'b0, a_i} + {1'b0, b_i};
  assign got_s   = {sum_co_o, sum_o};
  assign got_1   = {inc1_co_o, inc1_o};
  assign got_2   = {inc2_co_o, inc2_o};
  assign got_r   = {rnd_co_o, rnd_o};
  assign up_pos  = (mode_i == 2'b01) && !sign_i;
  assign up_neg  = (mode_i == 2'b10) && sign_i;
  assign any_bit = ref_ab[0] | guard_i | round_i | sticky_i;

  always_comb begin
    AST_SUM_EXACT: assert (got_s == ref_ab) else $error("sum mismatch"); // R1
    AST_PLUS_ONE: assert (got_1 == got_s + 1'b1) else $error("plus one mismatch"); // R2
    AST_PLUS_TWO: assert (got_2 == got_1 + 1'b1) else $error("plus two mismatch"); // R3
    AST_OVF_FLAG: assert (sum_co_o == ref_ab[DATA_W]) else $error("overflow flag mismatch"); // R5
    AST_RND_POS_OVF: assert (!(up_pos && any_bit && ref_ab[DATA_W]) || got_r == got_2) else $error("pos round"); // R6
    AST_RND_NO_OVF: assert (!((up_pos || up_neg) && any_bit && !ref_ab[DATA_W]) || got_r == got_1) else $error("round step"); // R7
    AST_RND_NEG_OVF: assert (!(up_neg && any_bit && ref_ab[DATA_W]) || got_r == got_2) else $error("neg round"); // R8
    AST_RND_TRUNC: assert (((up_pos || up_neg) && any_bit) || got_r == got_s) else $error("truncate"); // R9
    AST_PASS_VALID: assert (out_valid_o == in_valid_i) else $error("valid passthrough"); // R10
    AST_PASS_READY: assert (in_ready_i == out_ready_i) else $error("ready passthrough"); // R10
  end
endmodule

bind compound_adder compound_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .in_valid_i  (in_valid_i),
  .in_ready_i  (in_ready_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .guard_i     (guard_i),
  .round_i     (round_i),
  .sticky_i    (sticky_i),
  .sign_i      (sign_i),
  .mode_i      (mode_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .sum_o       (sum_o),
  .sum_co_o    (sum_co_o),
  .inc1_o      (inc1_o),
  .inc1_co_o   (inc1_co_o),
  .inc2_o      (inc2_o),
  .inc2_co_o   (inc2_co_o),
  .rnd_o       (rnd_o),
  .rnd_co_o    (rnd_co_o)
);

// File: tb/test_compound_adder.sv
module test_compound_adder;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        g;
    logic        r;
    logic        s;
    logic        sign;
    logic [1:0]  mode;
    logic [1:0]  pick; // 0: A+B, 1: A+B+1, 2: A+B+2
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MSB  = 64'h8000_0000_0000_0000;

  localparam vec_t VECS [0:14] = '{
    '{64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'd0},
    '{64'd0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 2'd1},
    '{ONES, 64'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'd0},
    '{ONES, 64'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 2'd2},
    '{ONES, ONES, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 2'd0},
    '{ONES, ONES, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 2'd2},
    '{ONES, ONES, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 2'd0},
    '{64'd3, 64'd5, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'd0},
    '{64'd3, 64'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'd1},
    '{MSB, MSB, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'd0},
    '{MSB, MSB, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 2'd2},
    '{64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 2'd1},
    '{64'd6, 64'd2, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 2'd0},
    '{64'd5, 64'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 2'd0},
    '{MSB, MSB | 64'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [DW-1:0] a, b;
  logic          g, r, s, sign;
  logic [1:0]    mode;
  logic [DW-1:0] sum_v, inc1_v, inc2_v, rnd_v;
  logic          sum_c, inc1_c, inc2_c, rnd_c;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  compound_adder #(.DATA_W(DW), .SECT_W(16)) i_compound_adder (
    .in_valid_i  (in_valid),
    .in_ready_i  (in_ready),
    .a_i         (a),
    .b_i         (b),
    .guard_i     (g),
    .round_i     (r),
    .sticky_i    (s),
    .sign_i      (sign),
    .mode_i      (mode),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .sum_o       (sum_v),
    .sum_co_o    (sum_c),
    .inc1_o      (inc1_v),
    .inc1_co_o   (inc1_c),
    .inc2_o      (inc2_v),
    .inc2_co_o   (inc2_c),
    .rnd_o       (rnd_v),
    .rnd_co_o    (rnd_c)
  );

  task automatic chk(input string req, input logic [DW:0] got, input logic [DW:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [DW-1:0] av, input logic [DW-1:0] bv,
                       input logic gv, input logic rv, input logic sv,
                       input logic sg, input logic [1:0] md);
    @(negedge clk);
    a = av; b = bv; g = gv; r = rv; s = sv; sign = sg; mode = md;
    #1;
  endtask

  task automatic check_sums(input string pfx);
    logic [DW:0] e0, e1, e2;
    e0 = {1'b0, a} + {1'b0, b};
    e1 = e0 + 1'b1;
    e2 = e0 + 2'd2;
    chk({pfx, " R1 sum"}, {sum_c, sum_v}, e0);
    chk({pfx, " R2 plus1"}, {inc1_c, inc1_v}, e1);
    chk({pfx, " R3 plus2"}, {inc2_c, inc2_v}, e2);
    chk({pfx, " R5 overflow"}, {{DW{1'b0}}, sum_c}, {{DW{1'b0}}, e0[DW]});
  endtask

  initial begin
    in_valid = 1'b0; out_ready = 1'b0;
    a = '0; b = '0; g = 1'b0; r = 1'b0; s = 1'b0; sign = 1'b0; mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset out_valid", {{DW{1'b0}}, out_valid}, '0);
    chk("R10 reset in_ready", {{DW{1'b0}}, in_ready}, '0);
    rst_n = 1'b1;

    // R10: same-cycle handshake
    @(negedge clk); in_valid = 1'b1; #1;
    chk("R10 valid high", {{DW{1'b0}}, out_valid}, {{DW{1'b0}}, 1'b1});
    @(negedge clk); out_ready = 1'b1; #1;
    chk("R10 ready high", {{DW{1'b0}}, in_ready}, {{DW{1'b0}}, 1'b1});
    @(negedge clk); out_ready = 1'b0; #1;
    chk("R10 ready low", {{DW{1'b0}}, in_ready}, '0);
    out_ready = 1'b1;

    // table walk: R6, R7, R8, R9 with sums
    for (int i = 0; i < 15; i++) begin
      logic [DW:0] e0, exp_r;
      string tag;
      drive(VECS[i].a, VECS[i].b, VECS[i].g, VECS[i].r, VECS[i].s,
            VECS[i].sign, VECS[i].mode);
      check_sums($sformatf("vec%0d", i));
      e0 = {1'b0, a} + {1'b0, b};
      exp_r = e0 + {{(DW-1){1'b0}}, VECS[i].pick};
      if (VECS[i].pick == 2'd2) tag = VECS[i].sign ? "R8" : "R6";
      else if (VECS[i].pick == 2'd1) tag = "R7";
      else tag = "R9";
      chk($sformatf("%s rounded vec%0d", tag, i), {rnd_c, rnd_v}, exp_r);
    end

    // R3: all-ones pair wraps A+B+2 to zero
    drive(ONES, ONES, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R3 wrap", {inc2_c, inc2_v}, '0);

    // R4: both parities of bit 0 of A xor B, random operands
    for (int k = 0; k < 60; k++) begin
      logic [DW-1:0] av, bv;
      av = {$urandom(), $urandom()};
      bv = {$urandom(), $urandom()};
      bv[0] = av[0] ^ k[0];
      if (k % 10 == 0) av = ONES;
      drive(av, bv, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
      check_sums($sformatf("R4 par%0d", k[0]));
    end

    // R9: reserved mode and mismatched sign with overflow and sticky
    drive(ONES, 64'd3, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11);
    chk("R9 reserved mode", {rnd_c, rnd_v}, {1'b0, ONES} + 65'd3);
    drive(ONES, 64'd3, 1'b1, 1'b1, 1'b1, 1'b1, 2'b01);
    chk("R9 sign mismatch", {rnd_c, rnd_v}, {1'b0, ONES} + 65'd3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule